// File: doc/BRIEF.md
# Conversion Sequence Controller with Result File

This block runs sequences of one to eight conversions over eight input channels for an external converter engine. For each conversion it offers a channel number on a valid/ready request channel. It then takes the engine's 10-bit result on a valid/ready result channel and files it in an eight-entry result store. A result goes either to the slot matching its position in the sequence or to the next slot of a circular FIFO. Per-slot complete flags, a sequence-complete flag with an interrupt, an overwrite flag and a conversion counter show software where the data stands.

Software drives two write strobes. A control write loads the length code, FIFO mode, fast-clear mode, interrupt enable and result format, and stops any running sequence. A start write picks the first channel, single or multi-channel operation and one-shot or continuous scan, then begins a fresh sequence. Results are read back through an index port, formatted left or right justified, 10-bit or 8-bit, signed or unsigned. Back-pressure rules: at most one request is outstanding. `req_valid` stays high until `req_ready` is seen. `res_ready` is high only while a request is outstanding. A result offered while `res_ready` is low, or in the same cycle as either write strobe, is dropped.

Top module: `conv_seq_ctrl`

## Requirements
- R1: The length code (`ctl_len`) gives codes 1 to 7 that many conversions, and gives code 0 or any code of 8 or more 8 conversions. After reset the code is 4.
- R2: With `start_multi`=0, every request of the sequence carries `start_chan`.
- R3: With `start_multi`=1, the first request carries `start_chan` and each later one the next channel, wrapping from 7 to 0.
- R4: With `ctl_fifo`=0, conversion k of a sequence (k from 0) is stored in slot k, and `conv_cnt` is 0 after the sequence ends.
- R5: With `ctl_fifo`=1, `conv_cnt` keeps counting across sequence boundaries, advancing by one per result and wrapping from 7 to 0. A start write still sets it to 0.
- R6: A start write stops any running sequence, clears `conv_cnt`, all complete flags, `seq_done` and `ovr_flag`, and starts a new sequence. A control write stops the sequence and clears `conv_cnt`, but keeps the flags and starts nothing.
- R7: Slot flag i (`done_flags[i]`) sets when a result is stored in slot i. With `ctl_fast`=0 it clears only on a read of slot i that follows a status read (`stat_rd`) that saw the flag set. A slot read with no such status read before it leaves the flag unchanged.
- R8: With `ctl_fast`=1, any read of slot i clears `done_flags[i]` and `seq_done`.
- R9: `seq_done` sets when each sequence ends. It clears on `clr_seq` or on a start write. `irq` is high exactly while `seq_done` and the interrupt enable are both set.
- R10: `ovr_flag` sets when a result is stored in a slot whose flag is still set. It clears on `clr_ovr` or on a start write.
- R11: With `start_scan`=1, the next sequence starts again from `start_chan` with no idle cycle after the previous one ends. With `start_scan`=0, the block goes idle (`busy`=0).
- R12: `rd_data` formats slot `res_idx` as follows. Left justified (`ctl_left`=1) puts the 10-bit value in bits 15:6, or its top 8 bits in bits 15:8 when `ctl_narrow`=1. Right justified puts them in bits 9:0 or 7:0. `ctl_signed`=1 inverts bit 15 in left-justified form only and is ignored in right-justified form. All other bits are 0.
- R13: At most one request is outstanding: `req_valid` and `res_ready` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control write strobe (stops the sequence) |
| ctl_len | input | 4 | Sequence length code |
| ctl_fifo | input | 1 | 1: circular FIFO placement |
| ctl_fast | input | 1 | 1: fast flag-clear scheme |
| ctl_irq_en | input | 1 | Interrupt enable |
| ctl_left | input | 1 | 1: left-justified results |
| ctl_signed | input | 1 | 1: offset-binary signed results |
| ctl_narrow | input | 1 | 1: 8-bit result view |
| start_wr | input | 1 | Start write strobe |
| start_chan | input | 3 | First channel |
| start_multi | input | 1 | 1: step the channel per conversion |
| start_scan | input | 1 | 1: continuous scan |
| stat_rd | input | 1 | Status read strobe |
| res_rd | input | 1 | Result read strobe |
| res_idx | input | 3 | Slot to read |
| clr_seq | input | 1 | Write-1 clear of seq_done |
| clr_ovr | input | 1 | Write-1 clear of ovr_flag |
| req_valid | output | 1 | Conversion request valid |
| req_ready | input | 1 | Engine accepts the request |
| req_chan | output | 3 | Channel to convert |
| res_valid | input | 1 | Engine result valid |
| res_ready | output | 1 | Block accepts a result |
| res_data | input | 10 | Engine result |
| rd_data | output | 16 | Formatted slot contents |
| done_flags | output | 8 | Per-slot complete flags |
| seq_done | output | 1 | Sequence-complete flag |
| ovr_flag | output | 1 | Overwrite flag |
| irq | output | 1 | Interrupt request |
| conv_cnt | output | 3 | Slot that the next result goes to |
| busy | output | 1 | Sequence running |

## Verification
A wrong sequence position or channel register shows up on `req_chan` at the very next request. A counter that is reset or advanced at the wrong moment sends the next result to the wrong slot. That error shows one cycle after the result handshake, either as the wrong bit rising in `done_flags` or as a false `ovr_flag`. Flag-clear faults show one cycle after the offending read strobe. Formatting faults are combinational and show on `rd_data` in the same cycle as `res_idx`.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  // Decode a raw length code into a conversion count of 1..n_ent.
  function automatic int unsigned seq_len(input int unsigned code, input int unsigned n_ent);
    return (code == 0 || code >= n_ent) ? n_ent : code;
  endfunction

  typedef struct packed {
    logic left;
    logic sgn;
    logic narrow;
  } fmt_cfg_t;
endpackage

// File: rtl/conv_seq_fsm.sv
module conv_seq_fsm #(
  parameter int unsigned N_ENT = 8,
  parameter int unsigned CH_W  = 3,
  localparam int unsigned IDX_W  = $clog2(N_ENT),
  localparam int unsigned LCNT_W = $clog2(N_ENT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_wr,
  input  logic              ctl_wr,
  input  logic [CH_W-1:0]   start_chan,
  input  logic              start_multi,
  input  logic              start_scan,
  input  logic [LCNT_W-1:0] len_cnt,
  input  logic              fifo_mode,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [CH_W-1:0]   req_chan,
  input  logic              res_valid,
  output logic              res_ready,
  output logic              take,
  output logic              seq_end,
  output logic [IDX_W-1:0]  cnt,
  output logic              busy
);
  logic              run, waiting, multi_q, scan_q;
  logic [IDX_W-1:0]  pos;
  logic [CH_W-1:0]   chan, base_chan;
  logic              abort, last;

  assign abort     = start_wr | ctl_wr;
  assign req_valid = run & ~waiting;
  assign res_ready = waiting;
  assign req_chan  = chan;
  assign busy      = run;
  assign take      = res_valid & waiting & ~abort;
  assign last      = (LCNT_W'(pos) + LCNT_W'(1)) == len_cnt;
  assign seq_end   = take & last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; waiting <= 1'b0; pos <= '0; cnt <= '0;
      chan <= '0; base_chan <= '0; multi_q <= 1'b0; scan_q <= 1'b0;
    end else if (abort) begin
      run     <= start_wr;
      waiting <= 1'b0;
      pos     <= '0;
      cnt     <= '0;
      if (start_wr) begin
        chan      <= start_chan;
        base_chan <= start_chan;
        multi_q   <= start_multi;
        scan_q    <= start_scan;
      end
    end else begin
      if (req_valid && req_ready) waiting <= 1'b1;
      if (take) begin
        waiting <= 1'b0;
        if (!fifo_mode && last)                cnt <= '0;
        else if (cnt == IDX_W'(N_ENT - 1))     cnt <= '0;
        else                                   cnt <= cnt + 1'b1;
        if (last) begin
          pos  <= '0;
          chan <= base_chan;
          run  <= scan_q;
        end else begin
          pos  <= pos + 1'b1;
          if (multi_q) chan <= chan + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/conv_result_file.sv
module conv_result_file #(
  parameter int unsigned N_ENT = 8,
  parameter int unsigned RES_W = 10,
  localparam int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_wr,
  input  logic             take,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [RES_W-1:0] wr_data,
  input  logic             seq_end,
  input  logic             stat_rd,
  input  logic             res_rd,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             fast_clr,
  input  logic             clr_seq,
  input  logic             clr_ovr,
  output logic [RES_W-1:0] rd_raw,
  output logic [N_ENT-1:0] flags,
  output logic             seq_flag,
  output logic             ovr
);
  logic [RES_W-1:0] mem [N_ENT];
  logic [N_ENT-1:0] armed;

  assign rd_raw = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (take) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      armed <= '0;
    end else begin
      for (int i = 0; i < N_ENT; i++) begin
        if (start_wr) begin
          flags[i] <= 1'b0;
          armed[i] <= 1'b0;
        end else if (take && wr_idx == IDX_W'(i)) begin
          flags[i] <= 1'b1;
          armed[i] <= 1'b0;
        end else if (res_rd && rd_idx == IDX_W'(i) && (fast_clr || armed[i])) begin
          flags[i] <= 1'b0;
          armed[i] <= 1'b0;
        end else if (stat_rd) begin
          armed[i] <= flags[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_flag <= 1'b0;
      ovr      <= 1'b0;
    end else begin
      if (start_wr)                            seq_flag <= 1'b0;
      else if (seq_end)                        seq_flag <= 1'b1;
      else if (clr_seq || (fast_clr && res_rd)) seq_flag <= 1'b0;

      if (start_wr)                            ovr <= 1'b0;
      else if (take && flags[wr_idx])          ovr <= 1'b1;
      else if (clr_ovr)                        ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/conv_result_fmt.sv
module conv_result_fmt
  import conv_seq_pkg::*;
#(
  parameter int unsigned RES_W    = 10,
  parameter int unsigned NARROW_W = 8,
  parameter int unsigned OUT_W    = 16
) (
  input  logic [RES_W-1:0] raw,
  input  fmt_cfg_t         cfg,
  output logic [OUT_W-1:0] out
);
  logic [RES_W-1:0]    wide;
  logic [NARROW_W-1:0] slim;

  always_comb begin
    wide = raw;
    slim = raw[RES_W-1 -: NARROW_W];
    if (cfg.left && cfg.sgn) begin
      wide[RES_W-1]    = ~wide[RES_W-1];
      slim[NARROW_W-1] = ~slim[NARROW_W-1];
    end
    out = '0;
    if (cfg.left) begin
      if (cfg.narrow) out[OUT_W-1 -: NARROW_W] = slim;
      else            out[OUT_W-1 -: RES_W]    = wide;
    end else begin
      if (cfg.narrow) out[NARROW_W-1:0] = slim;
      else            out[RES_W-1:0]    = wide;
    end
  end
endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
  import conv_seq_pkg::*;
#(
  parameter int unsigned N_ENT   = 8,
  parameter int unsigned CH_W    = 3,
  parameter int unsigned RES_W   = 10,
  parameter int unsigned OUT_W   = 16,
  parameter int unsigned LEN_W   = 4,
  parameter int unsigned LEN_RST = 4,
  localparam int unsigned IDX_W  = $clog2(N_ENT),
  localparam int unsigned LCNT_W = $clog2(N_ENT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [LEN_W-1:0] ctl_len,
  input  logic             ctl_fifo,
  input  logic             ctl_fast,
  input  logic             ctl_irq_en,
  input  logic             ctl_left,
  input  logic             ctl_signed,
  input  logic             ctl_narrow,
  input  logic             start_wr,
  input  logic [CH_W-1:0]  start_chan,
  input  logic             start_multi,
  input  logic             start_scan,
  input  logic             stat_rd,
  input  logic             res_rd,
  input  logic [IDX_W-1:0] res_idx,
  input  logic             clr_seq,
  input  logic             clr_ovr,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [CH_W-1:0]  req_chan,
  input  logic             res_valid,
  output logic             res_ready,
  input  logic [RES_W-1:0] res_data,
  output logic [OUT_W-1:0] rd_data,
  output logic [N_ENT-1:0] done_flags,
  output logic             seq_done,
  output logic             ovr_flag,
  output logic             irq,
  output logic [IDX_W-1:0] conv_cnt,
  output logic             busy
);
  logic [LEN_W-1:0]  len_q;
  logic              fifo_q, fast_q, ie_q;
  fmt_cfg_t          fmt_q;
  logic [LCNT_W-1:0] len_cnt;
  logic              take, seq_end;
  logic [RES_W-1:0]  rd_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q  <= LEN_W'(LEN_RST);
      fifo_q <= 1'b0; fast_q <= 1'b0; ie_q <= 1'b0;
      fmt_q  <= '0;
    end else if (ctl_wr) begin
      len_q  <= ctl_len;
      fifo_q <= ctl_fifo;
      fast_q <= ctl_fast;
      ie_q   <= ctl_irq_en;
      fmt_q  <= '{left: ctl_left, sgn: ctl_signed, narrow: ctl_narrow};
    end
  end

  assign len_cnt = LCNT_W'(seq_len(int'(len_q), N_ENT));
  assign irq     = seq_done & ie_q;

  conv_seq_fsm #(.N_ENT(N_ENT), .CH_W(CH_W)) u_fsm (
    .clk, .rst_n, .start_wr, .ctl_wr, .start_chan, .start_multi, .start_scan,
    .len_cnt, .fifo_mode(fifo_q), .req_valid, .req_ready, .req_chan,
    .res_valid, .res_ready, .take, .seq_end, .cnt(conv_cnt), .busy
  );

  conv_result_file #(.N_ENT(N_ENT), .RES_W(RES_W)) u_file (
    .clk, .rst_n, .start_wr, .take, .wr_idx(conv_cnt), .wr_data(res_data),
    .seq_end, .stat_rd, .res_rd, .rd_idx(res_idx), .fast_clr(fast_q),
    .clr_seq, .clr_ovr, .rd_raw, .flags(done_flags), .seq_flag(seq_done),
    .ovr(ovr_flag)
  );

  conv_result_fmt #(.RES_W(RES_W), .OUT_W(OUT_W)) u_fmt (
    .raw(rd_raw), .cfg(fmt_q), .out(rd_data)
  );
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk #(
  parameter int unsigned N_ENT = 8,
  localparam int unsigned IDX_W = $clog2(N_ENT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_wr,
  input logic             ctl_wr,
  input logic             req_valid,
  input logic             res_valid,
  input logic             res_ready,
  input logic [N_ENT-1:0] done_flags,
  input logic             seq_done,
  input logic             ovr_flag,
  input logic             irq,
  input logic [IDX_W-1:0] conv_cnt,
  input logic             busy
);
  // R7: an accepted result sets the flag of the slot it went to
  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && !start_wr && !ctl_wr) |=> done_flags[$past(conv_cnt)]);

  // R10: storing into a slot whose flag is set raises the overwrite flag
  p_ovr_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && !start_wr && !ctl_wr && done_flags[conv_cnt]) |=> ovr_flag);

  // R6: a start write leaves a clean, running sequence
  p_start_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> (conv_cnt == '0 && done_flags == '0 && !seq_done && !ovr_flag && busy));

  // R6: a control write alone stops the sequence
  p_ctl_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !start_wr) |=> (!busy && !req_valid && conv_cnt == '0));

  // R9: the interrupt never stands without the sequence flag
  p_irq_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> seq_done);

  // R13: one outstanding request at most
  p_one_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !res_ready);
endmodule

bind conv_seq_ctrl conv_seq_chk #(.N_ENT(N_ENT)) u_chk (.*);

// File: tb/sim_conv_seq_ctrl.sv
`timescale 1ns/1ps
module sim_conv_seq_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic ctl_wr, ctl_fifo, ctl_fast, ctl_irq_en, ctl_left, ctl_signed, ctl_narrow;
  logic [3:0] ctl_len;
  logic start_wr, start_multi, start_scan;
  logic [2:0] start_chan;
  logic stat_rd, res_rd, clr_seq, clr_ovr;
  logic [2:0] res_idx;
  logic req_valid, req_ready, res_valid, res_ready;
  logic [2:0] req_chan;
  logic [9:0] res_data;
  logic [15:0] rd_data;
  logic [7:0] done_flags;
  logic seq_done, ovr_flag, irq, busy;
  logic [2:0] conv_cnt;

  int errs = 0, checks = 0;
  bit finished = 0;
  logic [9:0] exp_mem [8];

  always #2 clk = ~clk;

  conv_seq_ctrl u0 (.*);

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] fexp(input logic [9:0] raw, input bit l, input bit s, input bit n);
    logic [15:0] v;
    int w;
    w = n ? 8 : 10;
    v = n ? 16'(raw >> 2) : 16'(raw);
    if (l) begin
      v = v << (16 - w);
      if (s) v = v ^ 16'h8000;
    end
    return v;
  endfunction

  task automatic ctl(input logic [3:0] len, input bit fifo, input bit fast,
                     input bit ie, input bit l, input bit s, input bit n);
    ctl_len = len; ctl_fifo = fifo; ctl_fast = fast; ctl_irq_en = ie;
    ctl_left = l; ctl_signed = s; ctl_narrow = n; ctl_wr = 1;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic start(input logic [2:0] ch, input bit m, input bit sc);
    start_chan = ch; start_multi = m; start_scan = sc; start_wr = 1;
    @(negedge clk); start_wr = 0;
  endtask

  task automatic pulse_stat();
    stat_rd = 1; @(negedge clk); stat_rd = 0;
  endtask

  task automatic pulse_rd(input logic [2:0] i);
    res_idx = i; res_rd = 1; @(negedge clk); res_rd = 0;
  endtask

  task automatic serve(input logic [2:0] ch, input logic [9:0] d, input string tag);
    int n = 0;
    while (!req_valid && n < 40) begin @(negedge clk); n++; end
    chk(tag, 32'(req_chan), 32'(ch));
    req_ready = 1; @(negedge clk); req_ready = 0;
    res_valid = 1; res_data = d; @(negedge clk); res_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [9:0] d;
    void'($urandom(32'd4711));
    rst_n = 0; ctl_wr = 0; ctl_len = 4; ctl_fifo = 0; ctl_fast = 0; ctl_irq_en = 0;
    ctl_left = 0; ctl_signed = 0; ctl_narrow = 0; start_wr = 0; start_chan = 0;
    start_multi = 0; start_scan = 0; stat_rd = 0; res_rd = 0; res_idx = 0;
    clr_seq = 0; clr_ovr = 0; req_ready = 0; res_valid = 0; res_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);

    // Reset state
    chk("R9 reset seq_done", 32'(seq_done), 0);
    chk("R7 reset flags", 32'(done_flags), 0);
    chk("R4 reset cnt", 32'(conv_cnt), 0);
    chk("R13 reset req_valid", 32'(req_valid), 0);
    chk("R10 reset ovr", 32'(ovr_flag), 0);

    // R1 reset length 4, R2 single channel 5
    start(3'd5, 0, 0);
    for (int k = 0; k < 4; k++) begin
      d = 10'($urandom); exp_mem[k] = d;
      if (k == 0) begin
        while (!req_valid) @(negedge clk);
        req_ready = 1; @(negedge clk); req_ready = 0;
        chk("R13 res_ready while waiting", 32'(res_ready), 1);
        chk("R13 no second request", 32'(req_valid), 0);
        chk("R2 chan", 32'(req_chan), 5);
        res_valid = 1; res_data = d; @(negedge clk); res_valid = 0;
      end else serve(3'd5, d, "R2 chan");
    end
    chk("R1 reset length 4 flags", 32'(done_flags), 32'h0F);
    chk("R9 seq_done set", 32'(seq_done), 1);
    chk("R11 one-shot idle", 32'(busy), 0);
    chk("R4 cnt zero at end", 32'(conv_cnt), 0);
    chk("R9 irq off when disabled", 32'(irq), 0);
    ctl(4, 0, 0, 1, 0, 0, 0);
    chk("R9 irq on when enabled", 32'(irq), 1);

    // R12 all format combinations on slot 2, R4 slot placement
    for (int f = 0; f < 8; f++) begin
      ctl(4, 0, 0, 1, f[0], f[1], f[2]);
      res_idx = 3'd2; @(negedge clk);
      chk("R12 format", 32'(rd_data), 32'(fexp(exp_mem[2], f[0], f[1], f[2])));
    end
    ctl(4, 0, 0, 1, 0, 0, 0);
    for (int k = 0; k < 4; k++) begin
      res_idx = 3'(k); @(negedge clk);
      chk("R4 slot k holds conversion k", 32'(rd_data), 32'(exp_mem[k]));
    end

    // R7 normal clear scheme
    pulse_rd(3'd0);
    chk("R7 read without status keeps flag", 32'(done_flags), 32'h0F);
    pulse_stat();
    pulse_rd(3'd0);
    chk("R7 status then read clears", 32'(done_flags), 32'h0E);
    chk("R8 normal read keeps seq_done", 32'(seq_done), 1);
    clr_seq = 1; @(negedge clk); clr_seq = 0;
    chk("R9 write-1 clears seq_done", 32'(seq_done), 0);
    chk("R9 irq follows", 32'(irq), 0);

    // R1 code 0 means 8, R3 multi-channel wrap from 6
    ctl(4'd0, 0, 0, 1, 0, 0, 0);
    start(3'd6, 1, 0);
    for (int k = 0; k < 8; k++) serve(3'(6 + k), 10'($urandom), "R3 multi chan");
    chk("R1 code 0 gives 8", 32'(done_flags), 32'hFF);
    chk("R6 start cleared flags, no ovr", 32'(ovr_flag), 0);

    // R11 scan, R10 overwrite, R6 control abort keeps flags
    ctl(4'd2, 0, 0, 1, 0, 0, 0);
    start(3'd1, 0, 1);
    serve(3'd1, 10'h11, "R11 chan");
    serve(3'd1, 10'h22, "R11 chan");
    chk("R11 seq_done after pass", 32'(seq_done), 1);
    chk("R11 request restarts at once", 32'(req_valid), 1);
    serve(3'd1, 10'h33, "R11 restart chan");
    chk("R10 overwrite set", 32'(ovr_flag), 1);
    ctl(4'd2, 0, 0, 1, 0, 0, 0);
    chk("R6 ctl abort stops", 32'(busy), 0);
    chk("R6 ctl abort keeps flags", 32'(done_flags), 32'h03);
    repeat (3) @(negedge clk);
    chk("R6 no request after abort", 32'(req_valid), 0);
    clr_ovr = 1; @(negedge clk); clr_ovr = 0;
    chk("R10 write-1 clears ovr", 32'(ovr_flag), 0);

    // R5 FIFO placement across passes
    ctl(4'd3, 1, 0, 1, 0, 0, 0);
    start(3'd0, 1, 1);
    for (int k = 0; k < 5; k++) serve(3'(k % 3), 10'(k), "R5 fifo chan");
    chk("R5 counter spans sequences", 32'(conv_cnt), 5);
    for (int k = 5; k < 8; k++) serve(3'(k % 3), 10'(k), "R5 fifo chan");
    chk("R5 counter wraps", 32'(conv_cnt), 0);
    chk("R5 all slots filled", 32'(done_flags), 32'hFF);
    chk("R10 no ovr yet", 32'(ovr_flag), 0);
    serve(3'd2, 10'h3FF, "R5 fifo chan");
    chk("R10 ovr on wrap", 32'(ovr_flag), 1);
    chk("R5 counter one", 32'(conv_cnt), 1);
    res_idx = 3'd5; @(negedge clk);
    chk("R5 slot 5 data", 32'(rd_data), 5);
    start(3'd3, 0, 0);
    chk("R5 start clears counter", 32'(conv_cnt), 0);
    chk("R6 start clears flags", 32'(done_flags), 0);
    chk("R6 start clears ovr", 32'(ovr_flag), 0);
    ctl(4'd3, 0, 0, 1, 0, 0, 0);

    // Random one-shot sequences, positional mode
    for (int it = 0; it < 24; it++) begin
      logic [3:0] code; logic [2:0] ch; bit m; int n;
      code = 4'($urandom); ch = 3'($urandom); m = 1'($urandom);
      n = (code == 0 || code >= 8) ? 8 : int'(code);
      ctl(code, 0, 0, 1, 0, 0, 0);
      start(ch, m, 0);
      for (int k = 0; k < n; k++) begin
        d = 10'($urandom); exp_mem[k] = d;
        serve(m ? 3'(ch + k) : ch, d, m ? "R3 rand chan" : "R2 rand chan");
      end
      chk("R1 rand length", 32'(done_flags), 32'((1 << n) - 1));
      chk("R4 rand cnt", 32'(conv_cnt), 0);
      res_idx = 3'(n - 1); @(negedge clk);
      chk("R4 rand last slot", 32'(rd_data), 32'(exp_mem[n - 1]));
    end

    // R8 fast clear
    ctl(4'd2, 0, 1, 1, 0, 0, 0);
    start(3'd4, 0, 0);
    serve(3'd4, 10'h0AA, "R2 chan");
    serve(3'd4, 10'h155, "R2 chan");
    chk("R9 seq_done before fast read", 32'(seq_done), 1);
    pulse_rd(3'd1);
    chk("R8 fast read clears slot flag", 32'(done_flags), 32'h01);
    chk("R8 fast read clears seq_done", 32'(seq_done), 0);

    // R6 abort mid-sequence
    ctl(4'd5, 0, 0, 1, 0, 0, 0);
    start(3'd0, 1, 0);
    serve(3'd0, 10'h1, "R3 chan");
    chk("R6 mid count", 32'(conv_cnt), 1);
    ctl(4'd5, 0, 0, 1, 0, 0, 0);
    chk("R6 mid abort cnt", 32'(conv_cnt), 0);
    chk("R6 mid abort idle", 32'(busy), 0);

    summary();
  end
endmodule